// File: doc/BRIEF.md
# Sample-Clock Delay Tuning Sweep Engine

This block searches for a reliable receive sampling delay for a high-speed SD card host. Once started, it walks a 7-bit delay code upward one step at a time. For each step it asks an external command/data path to run one tuning read, which is a single-block read of a 64-byte pattern. That path answers with pass or fail. A trial counts as failed when either the command phase or the data phase reports an error.

The search has three stages:

- It first looks for the lowest code that passes.
- It then looks for the last passing code above that one.
- It programs the midpoint of the two bounds and runs one more trial, whose result becomes the overall outcome.

While it runs, the engine drives three host control bits itself: tuning in progress, use the tuned sample clock, and feedback clock select. The trial delay code is presented inside a tune control word.

A host sequencer pulses `start` and waits for `done`. When `done` arrives it reads `pass_ok` and `chosen_code`. Between the trial request and its answer, the command/data path must read the delay from the tune control word.

Top module: `tune_sweep_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared from the next cycle on: `trial_req`, `tune_word`, `ctl_exec`, `ctl_tuned`, `ctl_fb`, `busy`, `done`, `pass_ok` and `chosen_code`.
- R2: A `start` pulse seen while idle sets `ctl_exec`, `ctl_tuned`, `ctl_fb` and `busy` in the following cycle. `ctl_exec` stays high until the run completes.
- R3: Each trial is requested by a one-cycle `trial_req`. At the same time `tune_word` carries the trial code in bits [14:8] and zeros in every other bit. `tune_word` holds until `trial_done`. The pass/fail result is taken from `trial_pass` in the cycle `trial_done` is high. A `trial_done` with no trial outstanding is ignored.
- R4: The lower-bound search tries codes 0, 1, 2, … and stops at the first passing code. If no code passes, it stops once the counter reaches 127, and no trial is made at 127. The code where it stops is the lower bound L.
- R5: The upper-bound search tries codes from L+1 upward while the code is below 127. At the first failing code C it stops, and the upper bound is U = C−1.
- R6: If no trial in the upper-bound search fails, U is the value the counter reached: 127, or 128 when L is 127. No trial is made at 127 or above in that search.
- R7: The final code is floor((L+U)/2), limited to at most 127. Exactly one more trial is run at that code. Its result appears on `pass_ok`, and the final code appears on `chosen_code`.
- R8: Completion is signalled by a one-cycle `done`. In that same cycle `ctl_exec` is low, while `ctl_tuned` and `ctl_fb` stay high. All three bits, and `pass_ok` and `chosen_code`, hold their values until the next start or reset.
- R9: A `start` pulse while `busy` is high is ignored. The sequence of trial codes and the final outcome are unchanged.
- R10: `trial_req` is raised only while `ctl_exec` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a sweep |
| trial_done | input | 1 | The outstanding tuning read has finished |
| trial_pass | input | 1 | Result of the tuning read, valid with `trial_done` |
| trial_req | output | 1 | One-cycle request to run a tuning read |
| tune_word | output | 16 | Tune control word; the trial delay code is in bits [14:8] |
| ctl_exec | output | 1 | Tuning-in-progress control bit |
| ctl_tuned | output | 1 | Use-tuned-sample-clock control bit |
| ctl_fb | output | 1 | Feedback clock select control bit |
| busy | output | 1 | A sweep is running |
| done | output | 1 | One-cycle completion pulse |
| pass_ok | output | 1 | Result of the final trial |
| chosen_code | output | 7 | Delay code chosen by the last sweep |

## Verification
A wrong bound counter or phase cannot stay hidden. It shows up on the very next `trial_req` as a delay field in `tune_word` that differs from the expected search order, so it is caught within one trial. A bad midpoint or a mishandled saturation case shows up on `chosen_code` and `pass_ok` in the `done` cycle. A control bit dropped or raised at the wrong moment is visible on the cycle it happens, because the control bits are compared against the expected run state every clock. The pass windows exercised are one in the middle of the range, one at code 0 only, one at the top, one at code 127 only, and an empty window.

// File: rtl/tune_sweep_pkg.sv
// Shared types for the sample-delay sweep engine.
// Assumes: nothing beyond the 1800-2017 language.
package tune_sweep_pkg;

    // Sequencer state: choose next trial, or wait for its answer.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_WAIT
    } seq_state_t;

    // Search stage: lower bound, upper bound, final midpoint check.
    typedef enum logic [1:0] {
        PH_LOW,
        PH_HIGH,
        PH_FINAL
    } sweep_phase_t;

endpackage

// File: rtl/tune_trial_port.sv
// Trial handshake port.
// Turns a one-cycle launch from the sequencer into a registered trial
// request, and places the code in the tune control word. Holds that word
// until the answer comes back, then returns a one-cycle result strobe.
// Assumes: the sequencer never launches while a trial is outstanding.
// Assumes: trial_done with no trial outstanding is noise and is dropped.
module tune_trial_port #(
    parameter int CODE_W     = 7,
    parameter int WORD_W     = 16,
    parameter int WORD_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [CODE_W-1:0] launch_code,
    input  logic              trial_done,
    input  logic              trial_pass,
    output logic              trial_req,
    output logic [WORD_W-1:0] tune_word,
    output logic              res_valid,
    output logic              res_pass
);
    localparam int PAD_W = WORD_W - CODE_W - WORD_SHIFT;

    logic waiting;

    // Issue the request, load the word, and track the outstanding trial.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_req <= 1'b0;
            tune_word <= '0;
            waiting   <= 1'b0;
        end else begin
            trial_req <= launch;
            if (launch) begin
                tune_word <= {{PAD_W{1'b0}}, launch_code, {WORD_SHIFT{1'b0}}};
                waiting   <= 1'b1;
            end else if (waiting && trial_done) begin
                waiting <= 1'b0;
            end
        end
    end

    // Capture the answer of the outstanding trial as a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
        end else begin
            res_valid <= waiting && trial_done;
            if (waiting && trial_done) begin
                res_pass <= trial_pass;
            end
        end
    end

    // R3
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trial_req |=> !trial_req);

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !trial_done) |=> $stable(tune_word));

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !waiting);

endmodule

// File: rtl/tune_sweep_ctrl.sv
// Sweep sequencer.
// Runs the three-stage delay search:
//   - lower bound: first passing code;
//   - upper bound: last passing code above it;
//   - a final check at the midpoint.
// Owns the three host control bits and the completion outputs.
// Assumes: one result strobe per launch, arriving any number of cycles
// later.
module tune_sweep_ctrl
    import tune_sweep_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              res_valid,
    input  logic              res_pass,
    output logic              launch,
    output logic [CODE_W-1:0] launch_code,
    output logic              ctl_exec,
    output logic              ctl_tuned,
    output logic              ctl_fb,
    output logic              busy,
    output logic              done,
    output logic              pass_ok,
    output logic [CODE_W-1:0] chosen_code
);
    localparam int              CNT_W    = CODE_W + 1;
    localparam logic [CNT_W-1:0] CODE_TOP = CNT_W'((1 << CODE_W) - 1);

    seq_state_t        state;
    sweep_phase_t      phase;
    logic [CNT_W-1:0]  lo_cnt;
    logic [CNT_W-1:0]  hi_cnt;
    logic [CODE_W-1:0] final_code;
    logic [CNT_W:0]    pair_sum;
    logic [CNT_W-1:0]  mid_raw;
    logic [CODE_W-1:0] mid_sat;

    // Midpoint of the window, limited to the top code.
    always_comb begin
        pair_sum = {1'b0, lo_cnt} + {1'b0, hi_cnt};
        mid_raw  = pair_sum[CNT_W:1];
        mid_sat  = (mid_raw > CODE_TOP) ? CODE_TOP[CODE_W-1:0] : mid_raw[CODE_W-1:0];
    end

    // Decide whether a trial goes out this cycle, and with which code.
    always_comb begin
        launch      = 1'b0;
        launch_code = mid_sat;
        if (state == ST_PICK) begin
            case (phase)
                PH_LOW: begin
                    launch      = lo_cnt < CODE_TOP;
                    launch_code = lo_cnt[CODE_W-1:0];
                end
                PH_HIGH: begin
                    launch      = hi_cnt < CODE_TOP;
                    launch_code = hi_cnt[CODE_W-1:0];
                end
                default: begin
                    launch      = 1'b1;
                    launch_code = mid_sat;
                end
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // Advance the search, update the bounds, drive the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase       <= PH_LOW;
            lo_cnt      <= '0;
            hi_cnt      <= '0;
            final_code  <= '0;
            chosen_code <= '0;
            ctl_exec    <= 1'b0;
            ctl_tuned   <= 1'b0;
            ctl_fb      <= 1'b0;
            done        <= 1'b0;
            pass_ok     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        lo_cnt    <= '0;
                        hi_cnt    <= '0;
                        phase     <= PH_LOW;
                        ctl_exec  <= 1'b1;
                        ctl_tuned <= 1'b1;
                        ctl_fb    <= 1'b1;
                        pass_ok   <= 1'b0;
                        state     <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    case (phase)
                        PH_LOW: begin
                            if (lo_cnt < CODE_TOP) begin
                                state <= ST_WAIT;
                            end else begin
                                hi_cnt <= lo_cnt + CNT_W'(1);
                                phase  <= PH_HIGH;
                            end
                        end
                        PH_HIGH: begin
                            if (hi_cnt < CODE_TOP) begin
                                state <= ST_WAIT;
                            end else begin
                                phase <= PH_FINAL;
                            end
                        end
                        default: begin
                            final_code <= mid_sat;
                            state      <= ST_WAIT;
                        end
                    endcase
                end
                default: begin
                    if (res_valid) begin
                        case (phase)
                            PH_LOW: begin
                                if (res_pass) begin
                                    hi_cnt <= lo_cnt + CNT_W'(1);
                                    phase  <= PH_HIGH;
                                end else begin
                                    lo_cnt <= lo_cnt + CNT_W'(1);
                                end
                                state <= ST_PICK;
                            end
                            PH_HIGH: begin
                                if (res_pass) begin
                                    hi_cnt <= hi_cnt + CNT_W'(1);
                                end else begin
                                    hi_cnt <= hi_cnt - CNT_W'(1);
                                    phase  <= PH_FINAL;
                                end
                                state <= ST_PICK;
                            end
                            default: begin
                                pass_ok     <= res_pass;
                                chosen_code <= final_code;
                                ctl_exec    <= 1'b0;
                                done        <= 1'b1;
                                state       <= ST_IDLE;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    lo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= CODE_TOP);

    // R5
    bound_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && phase != PH_LOW) |-> hi_cnt >= lo_cnt);

    // R3
    res_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> state == ST_WAIT);

endmodule

// File: rtl/tune_sweep_engine.sv
// Sample-delay tuning sweep engine, top level.
// Joins the search sequencer to the trial handshake port.
// Assumes: the external command/data path reads the delay field of
// tune_word when trial_req is seen, and answers with trial_done and
// trial_pass.
module tune_sweep_engine #(
    parameter int CODE_W     = 7,
    parameter int WORD_W     = 16,
    parameter int WORD_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              trial_done,
    input  logic              trial_pass,
    output logic              trial_req,
    output logic [WORD_W-1:0] tune_word,
    output logic              ctl_exec,
    output logic              ctl_tuned,
    output logic              ctl_fb,
    output logic              busy,
    output logic              done,
    output logic              pass_ok,
    output logic [CODE_W-1:0] chosen_code
);
    logic              launch;
    logic [CODE_W-1:0] launch_code;
    logic              res_valid;
    logic              res_pass;

    tune_sweep_ctrl #(
        .CODE_W(CODE_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .res_valid  (res_valid),
        .res_pass   (res_pass),
        .launch     (launch),
        .launch_code(launch_code),
        .ctl_exec   (ctl_exec),
        .ctl_tuned  (ctl_tuned),
        .ctl_fb     (ctl_fb),
        .busy       (busy),
        .done       (done),
        .pass_ok    (pass_ok),
        .chosen_code(chosen_code)
    );

    tune_trial_port #(
        .CODE_W    (CODE_W),
        .WORD_W    (WORD_W),
        .WORD_SHIFT(WORD_SHIFT)
    ) i_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_code(launch_code),
        .trial_done (trial_done),
        .trial_pass (trial_pass),
        .trial_req  (trial_req),
        .tune_word  (tune_word),
        .res_valid  (res_valid),
        .res_pass   (res_pass)
    );

    // R10
    req_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trial_req |-> ctl_exec);

    // R8
    done_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ctl_exec && ctl_tuned && ctl_fb));

endmodule

// File: tb/test_tune_sweep_engine.sv
// Bench for tune_sweep_engine.
// A behavioural model builds the expected trial-code order from the pass
// window. A negedge monitor compares the outputs with the model every
// cycle, and a stub answers each trial after a programmable latency.
module test_tune_sweep_engine;
    localparam int CODE_W   = 7;
    localparam int CODE_TOP = 127;
    localparam int WDOG     = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stub_done = 1'b0;
    logic        stub_pass = 1'b0;
    logic        stray_done = 1'b0;
    logic        trial_done;
    logic        trial_req;
    logic [15:0] tune_word;
    logic        ctl_exec, ctl_tuned, ctl_fb, busy, done, pass_ok;
    logic [CODE_W-1:0] chosen_code;
    logic        start_q = 1'b0;
    logic        rst_q = 1'b0;

    assign trial_done = stub_done | stray_done;

    always #2 clk = ~clk;

    tune_sweep_engine i_tune_sweep_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .trial_done(trial_done), .trial_pass(stub_pass),
        .trial_req(trial_req), .tune_word(tune_word),
        .ctl_exec(ctl_exec), .ctl_tuned(ctl_tuned), .ctl_fb(ctl_fb),
        .busy(busy), .done(done), .pass_ok(pass_ok), .chosen_code(chosen_code)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    win_lo = 1;
    int    win_hi = 0;
    int    lat = 1;
    int    exp_q[$];
    string tag_q[$];
    int    exp_code = 0;
    bit    exp_pass = 0;
    bit    mbusy = 0;
    bit    seen_done = 0;
    bit    prev_req = 0;
    bit    prev_done = 0;
    bit    timed_out = 0;
    int    cyc = 0;
    int    stub_cnt = 0;
    int    stub_code = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit in_win(input int c);
        return (c >= win_lo) && (c <= win_hi);
    endfunction

    // Expected trial order and outcome from the search rules.
    function automatic void build_model();
        int lo, hi, mid;
        bit hit_fail;
        int p2_first;
        exp_q.delete();
        tag_q.delete();
        lo = 0;
        while (lo < CODE_TOP) begin
            exp_q.push_back(lo); tag_q.push_back("R4");
            if (in_win(lo)) break;
            lo++;
        end
        hi = lo + 1;
        hit_fail = 0;
        p2_first = exp_q.size();
        while (hi < CODE_TOP) begin
            exp_q.push_back(hi); tag_q.push_back("R5");
            if (!in_win(hi)) begin hi--; hit_fail = 1; break; end
            hi++;
        end
        if (!hit_fail) begin
            for (int k = p2_first; k < tag_q.size(); k++) tag_q[k] = "R6";
        end
        mid = (lo + hi) / 2;
        if (mid > CODE_TOP) mid = CODE_TOP;
        exp_q.push_back(mid); tag_q.push_back("R7");
        exp_code = mid;
        exp_pass = in_win(mid);
    endfunction

    always @(posedge clk) begin
        start_q <= start;
        rst_q   <= rst_n;
    end

    // Per-cycle monitor, reference comparison and trial stub.
    always @(negedge clk) begin
        cyc++;
        if (cyc > WDOG) timed_out = 1;
        stub_done = 1'b0;
        if (!rst_q) begin
            stub_cnt = 0;
            prev_req = 0;
            prev_done = 0;
        end else begin
            if (start_q && !mbusy) mbusy = 1;
            check(ctl_exec == (mbusy && !done), "R2", "ctl_exec", ctl_exec, mbusy && !done);
            if (mbusy && !done) begin
                check(ctl_tuned && ctl_fb && busy, "R2", "tuned/fb/busy",
                      {ctl_tuned, ctl_fb, busy}, 7);
            end
            if (trial_req) begin
                check(ctl_exec, "R10", "req outside exec", ctl_exec, 1);
                check(!prev_req, "R3", "req longer than one cycle", prev_req, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R3", "unexpected trial code", int'(tune_word[14:8]), -1);
                end else begin
                    check(tune_word == 16'(exp_q[0] << 8), tag_q[0], "tune_word",
                          tune_word, exp_q[0] << 8);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
                stub_code = int'(tune_word[14:8]);
                stub_cnt  = lat;
            end else if (stub_cnt > 0) begin
                stub_cnt--;
                if (stub_cnt == 0) begin
                    stub_done = 1'b1;
                    stub_pass = in_win(stub_code);
                end
            end
            if (prev_done) check(!done, "R8", "done longer than one cycle", done, 0);
            if (done) begin
                check(mbusy, "R8", "done while idle", mbusy, 1);
                check(!ctl_exec && ctl_tuned && ctl_fb, "R8", "bits at done",
                      {ctl_exec, ctl_tuned, ctl_fb}, 3);
                check(chosen_code == CODE_W'(exp_code), "R7", "chosen_code",
                      chosen_code, exp_code);
                check(pass_ok == exp_pass, "R7", "pass_ok", pass_ok, exp_pass);
                check(exp_q.size() == 0, "R7", "trials left", exp_q.size(), 0);
                mbusy = 0;
                seen_done = 1;
            end
            prev_req = trial_req;
            prev_done = done;
        end
    end

    task automatic run_case(input int lo_w, input int hi_w, input int l,
                            input bit poke);
        win_lo = lo_w; win_hi = hi_w; lat = l;
        build_model();
        seen_done = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (15) @(negedge clk);
            start = 1'b1;   // R9: start while busy
            @(negedge clk); start = 1'b0;
        end
        while (!seen_done && !timed_out) @(negedge clk);
        repeat (4) @(negedge clk);
        check(!busy && ctl_tuned && ctl_fb && !ctl_exec, "R8", "hold after done",
              {busy, ctl_tuned, ctl_fb, ctl_exec}, 6);
        check(chosen_code == CODE_W'(exp_code), "R8", "chosen_code held",
              chosen_code, exp_code);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!trial_req && !done && !busy, "R1", "req/done/busy", {trial_req, done, busy}, 0);
        check(!ctl_exec && !ctl_tuned && !ctl_fb, "R1", "control bits",
              {ctl_exec, ctl_tuned, ctl_fb}, 0);
        check(tune_word == 0 && !pass_ok && chosen_code == 0, "R1", "result outputs",
              tune_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_case(20, 40, 1, 0);      // mid window
        run_case(0, 0, 2, 0);        // single passing code 0
        run_case(100, 127, 1, 0);    // R6: window reaches the top
        run_case(200, 0, 1, 0);      // empty window, final fails
        run_case(126, 127, 3, 0);    // R6: no upper-bound trials
        run_case(127, 127, 1, 0);    // only 127 passes; saturated midpoint
        run_case(20, 40, 4, 1);      // R9: start ignored while busy
        // R3: stray trial_done while idle is ignored
        @(negedge clk); stray_done = 1'b1;
        @(negedge clk); stray_done = 1'b0;
        repeat (6) @(negedge clk);
        check(!busy && !trial_req && !done, "R3", "stray done effect",
              {busy, trial_req, done}, 0);
        if (timed_out) check(0, "WDOG", "watchdog expired", cyc, WDOG);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule